// File: doc/BRIEF.md
# JEDEC Flash Command Sequence Decoder

This block sits behind the bus interface of a byte-wide flash array and turns already-latched, synchronous write cycles into flash operations. Each write arrives as a one-cycle `wr_valid` pulse carrying an address and a data byte. The decoder follows the multi-write unlock protocol. It tracks the current mode: normal read, identification, or fast-program (bypass). It raises one-cycle requests for the program/erase engine: program (with the target address and byte), chip erase, and reset/abort.

In identification mode the decoder answers reads on a separate read address. It returns the maker byte or the part byte, which it selects from the two lowest address bits. While the program/erase engine reports busy, writes are dropped. The one exception is an F0h write during an erase, which is passed on as an abort.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode_o` is 0 (read), `pgm_req`, `erase_req` and `reset_req` are low, and `id_valid` is low.
- R2: Address matching uses only `wr_addr[10:0]`. The upper address bits never change how a write is decoded.
- R3: When no program-data write is pending, a write of F0h to any address raises `reset_req` for one cycle and clears any partly entered sequence. After it, `mode_o` is 0, except in bypass mode (2), which is kept.
- R4: The unlock pair (AAh at 555h, then 55h at 2AAh) followed by 90h at 555h sets `mode_o` to 1 (identification). In that mode, a read address with bit 1 = 0 gives `id_valid`=1, and `id_data` is MFR_ID (20h) for bit 0 = 0 or DEV_ID (24h) for bit 0 = 1. With bit 1 = 1, `id_valid`=0 and `id_data`=00h. Outside mode 1, `id_valid` is 0.
- R5: The unlock pair, then A0h at 555h, then any write: the decoder raises `pgm_req` one cycle after that fourth write. `pgm_addr`/`pgm_data` then hold the fourth write's full address and data, and `mode_o` becomes 0.
- R6: The unlock pair, 80h at 555h, the unlock pair again, then 10h at 555h raise `erase_req` for one cycle, and `mode_o` becomes 0.
- R7: Outside bypass mode, a write that does not match the next expected step of any sequence returns `mode_o` to 0 and restarts decoding. The breaking write does not itself count as a first step.
- R8: The unlock pair followed by 20h at 555h sets `mode_o` to 2 (bypass). In bypass, A0h at any address followed by any write raises `pgm_req` with that write's address and data, and the mode stays 2.
- R9: In bypass, 90h followed by 00h returns `mode_o` to 0. 90h followed by any other byte, and any other unexpected write, leaves mode 2 with no request.
- R10: While `busy_i` is high, writes raise no program or erase request and leave mode and sequence progress unchanged. The exception is an F0h write while `erase_busy_i` is also high: it raises `reset_req` (abort).
- R11: At most one of the three requests is high in any cycle. A cycle without `wr_valid` raises none and leaves `mode_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data byte |
| busy_i | input | 1 | Program/erase engine busy |
| erase_busy_i | input | 1 | Engine busy with a chip erase |
| rd_addr | input | AW | Read address for identification bytes |
| mode_o | output | 2 | 0 read, 1 identification, 2 bypass |
| pgm_req | output | 1 | Program request pulse |
| pgm_addr | output | AW | Program target address |
| pgm_data | output | 8 | Program data byte |
| erase_req | output | 1 | Chip erase request pulse |
| reset_req | output | 1 | Reset / erase abort pulse |
| id_valid | output | 1 | Identification byte present on id_data |
| id_data | output | 8 | Identification byte |

## Verification
Mode and the three request pulses are registered. Each is due exactly one clock after the cycle that carries `wr_valid`, and the pulses last that one cycle only. The bench drives each write on a falling edge and drops the strobe on the next falling edge. It compares the outputs at that second falling edge, after the single capturing rising edge. The identification byte is combinational from `rd_addr` and the current mode, so it is checked in the same half cycle in which `rd_addr` changes.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int DW = 8;

  typedef enum logic [1:0] {
    MODE_READ   = 2'd0,
    MODE_IDSEL  = 2'd1,
    MODE_BYPASS = 2'd2
  } mode_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PGM_DATA,
    SQ_ERS1,
    SQ_ERS2,
    SQ_ERS3,
    SQ_BP_DATA,
    SQ_BP_EXIT
  } seq_e;

  localparam logic [DW-1:0] CODE_KEY1   = 8'hAA;
  localparam logic [DW-1:0] CODE_KEY2   = 8'h55;
  localparam logic [DW-1:0] CODE_RESET  = 8'hF0;
  localparam logic [DW-1:0] CODE_IDSEL  = 8'h90;
  localparam logic [DW-1:0] CODE_PGM    = 8'hA0;
  localparam logic [DW-1:0] CODE_ERSPRE = 8'h80;
  localparam logic [DW-1:0] CODE_ERSGO  = 8'h10;
  localparam logic [DW-1:0] CODE_BYPASS = 8'h20;
  localparam logic [DW-1:0] CODE_BPEXIT = 8'h00;

  localparam logic [31:0] ADR_CMD  = 32'h555;
  localparam logic [31:0] ADR_KEY2 = 32'h2AA;

  // decoded view of one write
  typedef struct packed {
    logic key1;    // AAh at the command address
    logic key2;    // 55h at the second unlock address
    logic at_cmd;  // address matches the command address
    logic rst;     // data is the reset code
  } wr_class_t;

  // compare only the low nbits of two addresses
  function automatic logic low_addr_eq(input logic [31:0] a,
                                       input logic [31:0] b,
                                       input int unsigned nbits);
    logic [31:0] mask;
    mask = (nbits >= 32) ? '1 : ((32'd1 << nbits) - 32'd1);
    return ((a ^ b) & mask) == 32'd0;
  endfunction

  // mode left behind by a reset: bypass survives, all else reads
  function automatic mode_e mode_after_reset(input mode_e m);
    return (m == MODE_BYPASS) ? MODE_BYPASS : MODE_READ;
  endfunction

  // identification byte selected by the two low read-address bits
  function automatic logic [DW-1:0] id_pick(input logic [1:0] sel,
                                            input logic [DW-1:0] mfr,
                                            input logic [DW-1:0] dev);
    if (sel[1]) return '0;
    return sel[0] ? dev : mfr;
  endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import fcd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CMP_BITS = 11
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output wr_class_t     cls
);

  logic [31:0] addr_w;
  logic        hit_cmd;
  logic        hit_key2;

  assign addr_w   = 32'(addr);
  assign hit_cmd  = low_addr_eq(addr_w, ADR_CMD, CMP_BITS);
  assign hit_key2 = low_addr_eq(addr_w, ADR_KEY2, CMP_BITS);

  always_comb begin
    cls.at_cmd = hit_cmd;
    cls.key1   = hit_cmd && (data == CODE_KEY1);
    cls.key2   = hit_key2 && (data == CODE_KEY2);
    cls.rst    = (data == CODE_RESET);
  end

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  wr_class_t     cls,
  input  logic          busy_i,
  input  logic          erase_busy_i,
  output mode_e         mode_q,
  output logic          pgm_req,
  output logic [AW-1:0] pgm_addr,
  output logic [DW-1:0] pgm_data,
  output logic          erase_req,
  output logic          reset_req,
  output logic          data_phase,
  output logic          wr_accept,
  output logic          wr_abort
);

  seq_e  st_q, st_d;
  mode_e mode_d;
  logic  pgm_d, ers_d, rst_d;

  assign data_phase = (st_q == SQ_PGM_DATA) || (st_q == SQ_BP_DATA);
  assign wr_accept  = wr_valid && !busy_i;
  assign wr_abort   = wr_valid && busy_i && erase_busy_i && cls.rst;

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    pgm_d  = 1'b0;
    ers_d  = 1'b0;
    rst_d  = 1'b0;
    if (wr_abort) begin
      rst_d  = 1'b1;
      st_d   = SQ_IDLE;
      mode_d = mode_after_reset(mode_q);
    end else if (wr_accept) begin
      if (data_phase) begin
        pgm_d = 1'b1;
        st_d  = SQ_IDLE;
        if (mode_q != MODE_BYPASS) mode_d = MODE_READ;
      end else if (cls.rst) begin
        rst_d  = 1'b1;
        st_d   = SQ_IDLE;
        mode_d = mode_after_reset(mode_q);
      end else if (mode_q == MODE_BYPASS) begin
        st_d = SQ_IDLE;
        if (st_q == SQ_BP_EXIT) begin
          if (wr_data == CODE_BPEXIT) mode_d = MODE_READ;
        end else if (wr_data == CODE_PGM) begin
          st_d = SQ_BP_DATA;
        end else if (wr_data == CODE_IDSEL) begin
          st_d = SQ_BP_EXIT;
        end
      end else begin
        // default outcome: a write that breaks the sequence
        st_d   = SQ_IDLE;
        mode_d = MODE_READ;
        unique case (st_q)
          SQ_IDLE: if (cls.key1) begin st_d = SQ_UNL1; mode_d = mode_q; end
          SQ_UNL1: if (cls.key2) begin st_d = SQ_UNL2; mode_d = mode_q; end
          SQ_UNL2: begin
            if (cls.at_cmd) begin
              unique case (wr_data)
                CODE_IDSEL:  mode_d = MODE_IDSEL;
                CODE_BYPASS: mode_d = MODE_BYPASS;
                CODE_PGM:    begin st_d = SQ_PGM_DATA; mode_d = mode_q; end
                CODE_ERSPRE: begin st_d = SQ_ERS1; mode_d = mode_q; end
                default:     mode_d = MODE_READ;
              endcase
            end
          end
          SQ_ERS1: if (cls.key1) begin st_d = SQ_ERS2; mode_d = mode_q; end
          SQ_ERS2: if (cls.key2) begin st_d = SQ_ERS3; mode_d = mode_q; end
          SQ_ERS3: if (cls.at_cmd && (wr_data == CODE_ERSGO)) ers_d = 1'b1;
          default: st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      mode_q    <= MODE_READ;
      pgm_req   <= 1'b0;
      erase_req <= 1'b0;
      reset_req <= 1'b0;
      pgm_addr  <= '0;
      pgm_data  <= '0;
    end else begin
      st_q      <= st_d;
      mode_q    <= mode_d;
      pgm_req   <= pgm_d;
      erase_req <= ers_d;
      reset_req <= rst_d;
      if (pgm_d) begin
        pgm_addr <= wr_addr;
        pgm_data <= wr_data;
      end
    end
  end

endmodule

// File: rtl/fcd_id.sv
module fcd_id
  import fcd_pkg::*;
#(
  parameter int             AW     = 16,
  parameter logic [DW-1:0]  MFR_ID = 8'h20,
  parameter logic [DW-1:0]  DEV_ID = 8'h24
) (
  input  mode_e         mode,
  input  logic [AW-1:0] rd_addr,
  output logic          id_valid,
  output logic [DW-1:0] id_data
);

  logic in_idsel;

  assign in_idsel = (mode == MODE_IDSEL);
  assign id_valid = in_idsel && !rd_addr[1];
  assign id_data  = in_idsel ? id_pick(rd_addr[1:0], MFR_ID, DEV_ID) : '0;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int             AW       = 16,
  parameter int             CMP_BITS = 11,
  parameter logic [7:0]     MFR_ID   = 8'h20,
  parameter logic [7:0]     DEV_ID   = 8'h24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          busy_i,
  input  logic          erase_busy_i,
  input  logic [AW-1:0] rd_addr,
  output logic [1:0]    mode_o,
  output logic          pgm_req,
  output logic [AW-1:0] pgm_addr,
  output logic [7:0]    pgm_data,
  output logic          erase_req,
  output logic          reset_req,
  output logic          id_valid,
  output logic [7:0]    id_data
);

  wr_class_t cls;
  mode_e     mode_q;
  logic      data_phase;
  logic      wr_accept;
  logic      wr_abort;

  fcd_classify #(.AW(AW), .CMP_BITS(CMP_BITS)) u_cls (
    .addr (wr_addr),
    .data (wr_data),
    .cls  (cls)
  );

  fcd_seq #(.AW(AW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .cls          (cls),
    .busy_i       (busy_i),
    .erase_busy_i (erase_busy_i),
    .mode_q       (mode_q),
    .pgm_req      (pgm_req),
    .pgm_addr     (pgm_addr),
    .pgm_data     (pgm_data),
    .erase_req    (erase_req),
    .reset_req    (reset_req),
    .data_phase   (data_phase),
    .wr_accept    (wr_accept),
    .wr_abort     (wr_abort)
  );

  fcd_id #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
    .mode     (mode_q),
    .rd_addr  (rd_addr),
    .id_valid (id_valid),
    .id_data  (id_data)
  );

  assign mode_o = mode_q;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int         AW     = 16,
  parameter logic [7:0] MFR_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'h24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          busy_i,
  input logic          erase_busy_i,
  input logic [AW-1:0] rd_addr,
  input logic [1:0]    mode_o,
  input logic          pgm_req,
  input logic [AW-1:0] pgm_addr,
  input logic [7:0]    pgm_data,
  input logic          erase_req,
  input logic          reset_req,
  input logic          id_valid,
  input logic [7:0]    id_data,
  input logic          data_phase
);

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_req, erase_req, reset_req})); // R11

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (!pgm_req && !erase_req && !reset_req && $stable(mode_o))); // R11

  AST_BUSY_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy_i) |=> (!pgm_req && !erase_req)); // R10

  AST_BUSY_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy_i && !(erase_busy_i && wr_data == 8'hF0)) |=> $stable(mode_o)); // R10

  AST_RESET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data == 8'hF0 && (busy_i ? erase_busy_i : !data_phase)) |=> reset_req); // R3

  AST_PGM_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> (pgm_addr == $past(wr_addr) && pgm_data == $past(wr_data))); // R5

  AST_ID_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && !rd_addr[1]) |-> (id_valid && id_data == (rd_addr[0] ? DEV_ID : MFR_ID))); // R4

  AST_ID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd1) |-> !id_valid); // R4

endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .busy_i       (busy_i),
  .erase_busy_i (erase_busy_i),
  .rd_addr      (rd_addr),
  .mode_o       (mode_o),
  .pgm_req      (pgm_req),
  .pgm_addr     (pgm_addr),
  .pgm_data     (pgm_data),
  .erase_req    (erase_req),
  .reset_req    (reset_req),
  .id_valid     (id_valid),
  .id_data      (id_data),
  .data_phase   (data_phase)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          busy_i = 1'b0;
  logic          erase_busy_i = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0]    mode_o;
  logic          pgm_req, erase_req, reset_req, id_valid;
  logic [AW-1:0] pgm_addr;
  logic [7:0]    pgm_data, id_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // reference model state: mode 0/1/2, step codes
  // 0 idle 1 unl1 2 unl2 3 pgm data 4..6 erase steps 7 bypass data 8 bypass exit
  int            m_mode = 0;
  int            m_st   = 0;
  bit            e_pgm, e_ers, e_rst;
  logic [AW-1:0] e_pa;
  logic [7:0]    e_pd;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy_i(busy_i), .erase_busy_i(erase_busy_i),
    .rd_addr(rd_addr), .mode_o(mode_o), .pgm_req(pgm_req),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data), .erase_req(erase_req),
    .reset_req(reset_req), .id_valid(id_valid), .id_data(id_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int expect_id(input logic [1:0] sel);
    if (sel[1]) return 0;
    return sel[0] ? 32'h24 : 32'h20;
  endfunction

  function automatic int after_reset(input int m);
    return (m == 2) ? 2 : 0;
  endfunction

  task automatic model_wr(input logic [AW-1:0] a, input logic [7:0] d,
                          input bit bz, input bit eb);
    bit k1, k2, c;
    int nst, nm;
    e_pgm = 0; e_ers = 0; e_rst = 0;
    if (bz) begin
      if (eb && d == 8'hF0) begin e_rst = 1; m_st = 0; m_mode = after_reset(m_mode); end
      return;
    end
    if (m_st == 3 || m_st == 7) begin
      e_pgm = 1; e_pa = a; e_pd = d;
      if (m_st == 3) m_mode = 0;
      m_st = 0;
      return;
    end
    if (d == 8'hF0) begin e_rst = 1; m_st = 0; m_mode = after_reset(m_mode); return; end
    if (m_mode == 2) begin
      if (m_st == 8) begin
        if (d == 8'h00) m_mode = 0;
        m_st = 0;
      end else if (d == 8'hA0) m_st = 7;
      else if (d == 8'h90) m_st = 8;
      return;
    end
    c  = (a[10:0] == 11'h555);
    k1 = c && d == 8'hAA;
    k2 = (a[10:0] == 11'h2AA) && d == 8'h55;
    nst = 0; nm = 0;
    case (m_st)
      0: if (k1) begin nst = 1; nm = m_mode; end
      1: if (k2) begin nst = 2; nm = m_mode; end
      2: if (c) begin
           if (d == 8'h90) nm = 1;
           else if (d == 8'h20) nm = 2;
           else if (d == 8'hA0) begin nst = 3; nm = m_mode; end
           else if (d == 8'h80) begin nst = 4; nm = m_mode; end
         end
      4: if (k1) begin nst = 5; nm = m_mode; end
      5: if (k2) begin nst = 6; nm = m_mode; end
      6: if (c && d == 8'h10) e_ers = 1;
      default: ;
    endcase
    m_st = nst; m_mode = nm;
  endtask

  // one write cycle, then compare outputs after the capturing edge
  task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    model_wr(a, d, busy_i, erase_busy_i);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(mode_o == 2'(m_mode), req, "mode", int'(mode_o), m_mode);
    chk(pgm_req == e_pgm, req, "pgm_req", int'(pgm_req), int'(e_pgm));
    chk(erase_req == e_ers, req, "erase_req", int'(erase_req), int'(e_ers));
    chk(reset_req == e_rst, req, "reset_req", int'(reset_req), int'(e_rst));
    if (e_pgm) begin
      chk(pgm_addr == e_pa, req, "pgm_addr", int'(pgm_addr), int'(e_pa));
      chk(pgm_data == e_pd, req, "pgm_data", int'(pgm_data), int'(e_pd));
    end
  endtask

  task automatic unlock(input logic [AW-1:0] hi, input string req);
    do_wr(hi | 16'h0555, 8'hAA, req);
    do_wr(hi | 16'h02AA, 8'h55, req);
  endtask

  task automatic chk_id(input logic [AW-1:0] ra, input string req);
    rd_addr = ra;
    #1;
    chk(id_valid == (m_mode == 1 && !ra[1]), req, "id_valid", int'(id_valid),
        int'(m_mode == 1 && !ra[1]));
    chk(int'(id_data) == ((m_mode == 1) ? expect_id(ra[1:0]) : 0), req, "id_data",
        int'(id_data), (m_mode == 1) ? expect_id(ra[1:0]) : 0);
  endtask

  function automatic logic [7:0] maybe_bad(input logic [7:0] d);
    return ($urandom % 12 == 0) ? 8'($urandom) : d;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mode_o == 2'd0, "R1", "mode", int'(mode_o), 0);
    chk(!pgm_req && !erase_req && !reset_req, "R1", "requests", 0, 0);
    chk(!id_valid, "R1", "id_valid", int'(id_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 / R2: identification with upper address bits set
    unlock(16'hF000, "R2");
    do_wr(16'h7555, 8'h90, "R4");
    chk(mode_o == 2'd1, "R4", "idsel mode", int'(mode_o), 1);
    chk_id(16'h0000, "R4");
    chk_id(16'hFF01, "R4");
    chk_id(16'h0002, "R4");
    chk_id(16'h0003, "R4");
    // R7: a stray write leaves identification
    do_wr(16'h0100, 8'h33, "R7");
    chk(mode_o == 2'd0, "R7", "drop to read", int'(mode_o), 0);
    chk_id(16'h0000, "R4");

    // R3 single reset write
    do_wr(16'h1234, 8'hF0, "R3");
    chk(reset_req, "R3", "reset pulse", int'(reset_req), 1);
    // R3 reset after the unlock pair
    unlock(16'h0000, "R3");
    do_wr(16'h0000, 8'hF0, "R3");

    // R5 program
    unlock(16'h0000, "R5");
    do_wr(16'h0555, 8'hA0, "R5");
    do_wr(16'hBEEF, 8'h5A, "R5");
    chk(pgm_req && pgm_addr == 16'hBEEF, "R5", "program", int'(pgm_addr), 32'hBEEF);

    // R6 chip erase
    unlock(16'h0000, "R6");
    do_wr(16'h0555, 8'h80, "R6");
    unlock(16'h8000, "R6");
    do_wr(16'h0555, 8'h10, "R6");
    chk(erase_req, "R6", "erase", int'(erase_req), 1);

    // R7 broken unlock: wrong second address, then 80h must do nothing
    do_wr(16'h0555, 8'hAA, "R7");
    do_wr(16'h02AB, 8'h55, "R7");
    do_wr(16'h0555, 8'h80, "R7");
    // R2: bit 11 differs yet still decodes as 555h
    do_wr(16'h0D55, 8'hAA, "R2");
    do_wr(16'h0AAA, 8'h55, "R2");
    do_wr(16'h0555, 8'h90, "R2");
    chk(mode_o == 2'd1, "R2", "high bits ignored", int'(mode_o), 1);

    // R8 bypass enter, fast program
    unlock(16'h0000, "R8");
    do_wr(16'h0555, 8'h20, "R8");
    chk(mode_o == 2'd2, "R8", "bypass mode", int'(mode_o), 2);
    do_wr(16'h4000, 8'hA0, "R8");
    do_wr(16'h00C3, 8'h3C, "R8");
    chk(pgm_req && mode_o == 2'd2, "R8", "bypass program", int'(mode_o), 2);
    // R3 reset in bypass keeps bypass
    do_wr(16'h0000, 8'hF0, "R3");
    chk(mode_o == 2'd2, "R3", "bypass kept", int'(mode_o), 2);
    // R9 ignored writes and failed exit
    do_wr(16'h0555, 8'hAA, "R9");
    do_wr(16'h0000, 8'h90, "R9");
    do_wr(16'h0000, 8'h11, "R9");
    chk(mode_o == 2'd2, "R9", "bad exit ignored", int'(mode_o), 2);
    do_wr(16'h0000, 8'h90, "R9");
    do_wr(16'h0000, 8'h00, "R9");
    chk(mode_o == 2'd0, "R9", "exit", int'(mode_o), 0);

    // R10 busy: progress held across ignored writes
    unlock(16'h0000, "R10");
    busy_i = 1'b1;
    do_wr(16'h0123, 8'h77, "R10");
    do_wr(16'h0000, 8'hF0, "R10");
    busy_i = 1'b0;
    do_wr(16'h0555, 8'hA0, "R10");
    busy_i = 1'b1;
    do_wr(16'h0042, 8'h99, "R10");
    busy_i = 1'b0;
    do_wr(16'h0042, 8'h24, "R10");
    chk(pgm_req && pgm_data == 8'h24, "R10", "held program", int'(pgm_data), 32'h24);
    // R10 abort during erase
    busy_i = 1'b1; erase_busy_i = 1'b1;
    do_wr(16'h0008, 8'hF0, "R10");
    chk(reset_req, "R10", "abort", int'(reset_req), 1);
    busy_i = 1'b0; erase_busy_i = 1'b0;

    // R11 random mix against the model
    for (int i = 0; i < 400; i++) begin
      int kind;
      kind = $urandom % 8;
      busy_i = ($urandom % 10 == 0);
      erase_busy_i = busy_i && ($urandom % 2 == 0);
      case (kind)
        0: do_wr(16'($urandom), maybe_bad(8'hF0), "R11");
        1: begin unlock(16'($urandom) & 16'hF800, "R11");
                  do_wr(16'h0555, maybe_bad(8'h90), "R11"); end
        2: begin unlock(16'h0000, "R11");
                  do_wr(16'h0555, maybe_bad(8'hA0), "R11");
                  do_wr(16'($urandom), 8'($urandom), "R11"); end
        3: begin unlock(16'h0000, "R11");
                  do_wr(16'h0555, maybe_bad(8'h80), "R11");
                  unlock(16'h0000, "R11");
                  do_wr(16'h0555, maybe_bad(8'h10), "R11"); end
        4: begin unlock(16'h0000, "R11");
                  do_wr(16'h0555, maybe_bad(8'h20), "R11"); end
        5: begin do_wr(16'($urandom), maybe_bad(8'hA0), "R11");
                  do_wr(16'($urandom), 8'($urandom), "R11"); end
        6: begin do_wr(16'($urandom), maybe_bad(8'h90), "R11");
                  do_wr(16'($urandom), maybe_bad(8'h00), "R11"); end
        default: do_wr(16'($urandom), 8'($urandom), "R11");
      endcase
      if (kind == 1) chk_id(16'($urandom), "R4");
    end
    busy_i = 1'b0; erase_busy_i = 1'b0;

    // R11 idle cycles: nothing moves
    @(negedge clk);
    chk(!pgm_req && !erase_req && !reset_req, "R11", "idle quiet", 0, 0);
    chk(mode_o == 2'(m_mode), "R11", "idle mode", int'(mode_o), m_mode);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule